// File: doc/BRIEF.md
# Keyboard and Character Display Register Block

This block sits on a 16-bit memory-mapped bus and gives a processor two simple character channels: one keyboard input and one character display output. The processor reaches four registers with ordinary load and store cycles at fixed addresses. A status register and a data register belong to each channel. Key codes enter through a valid/ready port. Characters leave through a second valid/ready port toward a display sink.

On the keyboard side an accepted key code is latched and a ready flag is raised. The channel then refuses further keys until the processor reads the keyboard data register, and that read clears the flag. On the display side a store to the display data register hands the character to the sink. The display ready bit stays low until the sink takes the character. Bus reads are combinational within the access cycle. The side effect of a read, and the effect of a store, take hold at the clock edge that ends the access.

Top module: `kbd_disp_regs`

## Requirements
- R1: After reset, keyboard status reads 0x0000, display status reads 0x8000, key_ready is 1 and out_valid is 0.
- R2: A key code offered with key_valid while key_ready is 1 is captured at that edge. From the next cycle keyboard status (0xF400) reads 0x8000 and keyboard data (0xF401) holds the code in bits 7:0.
- R3: While the keyboard ready flag is set, key_ready is 0 and offered key codes are refused, so the held code stays the same.
- R4: A bus read of keyboard data clears the ready flag at the end of that access, which raises key_ready again. A read of keyboard status leaves the flag set.
- R5: The registers decode at keyboard status 0xF400, keyboard data 0xF401, display status 0xF3FC and display data 0xF3FF. Any other address reads 0x0000.
- R6: Status registers carry only bit 15, and data registers carry only bits 7:0. All other read bits are 0. Stores to either status register change nothing.
- R7: A store to display data (0xF3FF) while the display is ready drives out_valid high with out_char equal to bits 7:0 of the stored word from the next cycle. Display status then reads 0x0000.
- R8: out_valid and out_char hold while out_ready is 0. One cycle after a transfer with out_valid and out_ready both 1, out_valid is 0 and display status reads 0x8000.
- R9: A store to display data while a character is still pending is ignored, so out_char does not change.
- R10: A read of display data returns the last accepted character in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = store, 0 = load |
| bus_addr | input | 16 | Word address |
| bus_wdata | input | 16 | Store data |
| bus_rdata | output | 16 | Load data, valid in the access cycle |
| key_valid | input | 1 | Key code offered |
| key_code | input | 8 | ASCII key code |
| key_ready | output | 1 | Keyboard can accept a code |
| out_valid | output | 1 | Character pending for the display sink |
| out_char | output | 8 | Character for the display sink |
| out_ready | input | 1 | Display sink accepts the character |

## Verification
A stuck or wrongly set keyboard flag shows at once on key_ready. It shows on the status read in the cycle after the offending edge. A missed clear on a data read leaves key_ready low on the very next cycle. A display channel that loses its pending state drops out_valid, or raises the status bit, one cycle early. A mis-latched character appears on out_char in the cycle after the store. Decoder faults are visible in the same cycle as the access, because read data is combinational.

// File: rtl/kdr_pkg.sv
// Package: shared constants and types for the keyboard/display register block.
// Assumes a 16-bit word-addressed bus with single-cycle accesses.
package kdr_pkg;
    localparam int BUS_W    = 16;
    localparam int CHAR_W   = 8;
    localparam int FLAG_BIT = 15;

    localparam logic [15:0] ADR_KSTAT = 16'hF400;
    localparam logic [15:0] ADR_KDATA = 16'hF401;
    localparam logic [15:0] ADR_DSTAT = 16'hF3FC;
    localparam logic [15:0] ADR_DDATA = 16'hF3FF;

    typedef enum logic [2:0] {
        HIT_NONE,
        HIT_KSTAT,
        HIT_KDATA,
        HIT_DSTAT,
        HIT_DDATA
    } reg_hit_e;
endpackage

// File: rtl/kdr_decode.sv
// Module: address decoder. It maps a bus access to one register and produces
// the two access strobes that carry side effects: a load of keyboard data and
// a store to display data. Assumes that one access lasts exactly one cycle.
module kdr_decode
    import kdr_pkg::*;
#(
    parameter int          ADDR_W = 16,
    parameter logic [ADDR_W-1:0] A_KSTAT = ADDR_W'(ADR_KSTAT),
    parameter logic [ADDR_W-1:0] A_KDATA = ADDR_W'(ADR_KDATA),
    parameter logic [ADDR_W-1:0] A_DSTAT = ADDR_W'(ADR_DSTAT),
    parameter logic [ADDR_W-1:0] A_DDATA = ADDR_W'(ADR_DDATA)
) (
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output reg_hit_e          hit,
    output logic              rd_kdata,
    output logic              wr_ddata
);
    // Register select from the address, qualified by the access strobe.
    always_comb begin
        hit = HIT_NONE;
        if (sel) begin
            unique case (addr)
                A_KSTAT: hit = HIT_KSTAT;
                A_KDATA: hit = HIT_KDATA;
                A_DSTAT: hit = HIT_DSTAT;
                A_DDATA: hit = HIT_DDATA;
                default: hit = HIT_NONE;
            endcase
        end
    end

    // Side-effect strobes.
    always_comb begin
        rd_kdata = (hit == HIT_KDATA) && !we;
        wr_ddata = (hit == HIT_DDATA) && we;
    end
endmodule

// File: rtl/kdr_key_chan.sv
// Module: keyboard channel. It latches one key code and raises a full flag.
// It refuses keys while full and empties when the processor takes the code.
// Assumes the take strobe is asserted for one cycle per bus read.
module kdr_key_chan #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    input  logic [CHAR_W-1:0] key_code,
    output logic              key_ready,
    input  logic              take,
    output logic              full,
    output logic [CHAR_W-1:0] code
);
    // The port accepts only while nothing is held.
    always_comb key_ready = !full;

    // Capture a key, or release the held key on a take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            code <= '0;
        end else if (key_valid && !full) begin
            full <= 1'b1;
            code <= key_code;
        end else if (take) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/kdr_disp_chan.sv
// Module: display channel. A store starts a transfer on a valid/ready port.
// While a character is pending, further stores are dropped. Assumes the sink
// follows the usual rule that valid is not withdrawn before ready.
module kdr_disp_chan #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CHAR_W-1:0] start_char,
    output logic              out_valid,
    output logic [CHAR_W-1:0] out_char,
    input  logic              out_ready,
    output logic              idle
);
    logic busy;

    // Status and port view of the pending state.
    always_comb begin
        out_valid = busy;
        idle      = !busy;
    end

    // Load on a store when idle, and drain when the sink accepts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            out_char <= '0;
        end else if (!busy && start) begin
            busy     <= 1'b1;
            out_char <= start_char;
        end else if (busy && out_ready) begin
            busy <= 1'b0;
        end
    end
endmodule

// File: rtl/kdr_rdmux.sv
// Module: read-data multiplexer. It forms the word for the selected register
// and zero-fills all bits that are not implemented. It is purely combinational.
module kdr_rdmux
    import kdr_pkg::*;
#(
    parameter int BUS_W    = 16,
    parameter int CHAR_W   = 8,
    parameter int FLAG_BIT = 15
) (
    input  reg_hit_e          hit,
    input  logic              kfull,
    input  logic [CHAR_W-1:0] kcode,
    input  logic              didle,
    input  logic [CHAR_W-1:0] dchar,
    output logic [BUS_W-1:0]  rdata
);
    localparam int PAD_W = BUS_W - CHAR_W;

    // Word assembly per register.
    always_comb begin
        rdata = '0;
        unique case (hit)
            HIT_KSTAT: rdata[FLAG_BIT] = kfull;
            HIT_KDATA: rdata = {{PAD_W{1'b0}}, kcode};
            HIT_DSTAT: rdata[FLAG_BIT] = didle;
            HIT_DDATA: rdata = {{PAD_W{1'b0}}, dchar};
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/kbd_disp_regs.sv
// Module: top of the keyboard/display register block. It joins the decoder,
// the two channels and the read multiplexer. Assumes single-cycle bus
// accesses and a synchronous active-low reset.
module kbd_disp_regs
    import kdr_pkg::*;
#(
    parameter int BUS_W    = kdr_pkg::BUS_W,
    parameter int CHAR_W   = kdr_pkg::CHAR_W,
    parameter int FLAG_BIT = kdr_pkg::FLAG_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              key_valid,
    input  logic [CHAR_W-1:0] key_code,
    output logic              key_ready,
    output logic              out_valid,
    output logic [CHAR_W-1:0] out_char,
    input  logic              out_ready
);
    reg_hit_e          hit;
    logic              rd_kdata;
    logic              wr_ddata;
    logic              kfull;
    logic [CHAR_W-1:0] kcode;
    logic              didle;

    kdr_decode #(.ADDR_W(BUS_W)) u_dec (
        .sel      (bus_sel),
        .we       (bus_we),
        .addr     (bus_addr),
        .hit      (hit),
        .rd_kdata (rd_kdata),
        .wr_ddata (wr_ddata)
    );

    kdr_key_chan #(.CHAR_W(CHAR_W)) u_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_valid (key_valid),
        .key_code  (key_code),
        .key_ready (key_ready),
        .take      (rd_kdata),
        .full      (kfull),
        .code      (kcode)
    );

    kdr_disp_chan #(.CHAR_W(CHAR_W)) u_disp (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (wr_ddata),
        .start_char (bus_wdata[CHAR_W-1:0]),
        .out_valid  (out_valid),
        .out_char   (out_char),
        .out_ready  (out_ready),
        .idle       (didle)
    );

    kdr_rdmux #(.BUS_W(BUS_W), .CHAR_W(CHAR_W), .FLAG_BIT(FLAG_BIT)) u_rd (
        .hit   (hit),
        .kfull (kfull),
        .kcode (kcode),
        .didle (didle),
        .dchar (out_char),
        .rdata (bus_rdata)
    );
endmodule

// File: rtl/kdr_checker.sv
// Module: port-level protocol checker for kbd_disp_regs, attached by bind.
module kdr_checker #(
    parameter int BUS_W  = 16,
    parameter int CHAR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [BUS_W-1:0]  bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic              key_valid,
    input logic [CHAR_W-1:0] key_code,
    input logic              key_ready,
    input logic              out_valid,
    input logic [CHAR_W-1:0] out_char,
    input logic              out_ready
);
    logic ld_kdata, st_ddata;
    always_comb begin
        ld_kdata = bus_sel && !bus_we && (bus_addr == BUS_W'(16'hF401));
        st_ddata = bus_sel && bus_we && (bus_addr == BUS_W'(16'hF3FF));
    end

    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && key_ready) |=> !key_ready);
    assert_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_ready && !ld_kdata) |=> !key_ready);
    assert_unlock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_ready && ld_kdata) |=> key_ready);
    assert_pad_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[BUS_W-2:CHAR_W] == '0);
    assert_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && st_ddata) |=> (out_valid && out_char == $past(bus_wdata[CHAR_W-1:0])));
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_char)));
    assert_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> !out_valid);
endmodule

bind kbd_disp_regs kdr_checker #(.BUS_W(BUS_W), .CHAR_W(CHAR_W)) u_chk (.*);

// File: tb/kbd_disp_regs_tb.sv
module kbd_disp_regs_tb;
    localparam logic [15:0] KSTAT = 16'hF400, KDATA = 16'hF401;
    localparam logic [15:0] DSTAT = 16'hF3FC, DDATA = 16'hF3FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [15:0] bus_addr = '0, bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        key_valid = 1'b0;
    logic [7:0]  key_code = '0;
    logic        key_ready, out_valid, out_ready = 1'b0;
    logic [7:0]  out_char;
    int          n_chk = 0, n_fail = 0, cyc = 0;

    always #2 clk = ~clk;

    kbd_disp_regs u_dut (.*);

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_read(logic [15:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic bus_write(logic [15:0] a, logic [15:0] w);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = w;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic offer_key(logic [7:0] c);
        @(negedge clk);
        key_valid = 1'b1; key_code = c;
        @(negedge clk);
        key_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        check("R1 key_ready", 16'(key_ready), 16'd1);
        check("R1 out_valid", 16'(out_valid), 16'd0);
        bus_read(KSTAT, d); check("R1 kstat", d, 16'h0000);
        bus_read(DSTAT, d); check("R1 dstat", d, 16'h8000);
    endtask

    task automatic t_key_lock();
        logic [15:0] d;
        offer_key(8'h41);
        bus_read(KSTAT, d); check("R2 kstat set", d, 16'h8000);
        bus_read(KSTAT, d); check("R4 status read keeps flag", d, 16'h8000);
        check("R3 key_ready low", 16'(key_ready), 16'd0);
        offer_key(8'h42);
        bus_read(KDATA, d); check("R3 refused key, R2 code", d, 16'h0041);
        check("R4 key_ready after take", 16'(key_ready), 16'd1);
        bus_read(KSTAT, d); check("R4 kstat cleared", d, 16'h0000);
        offer_key(8'hFF);
        bus_read(KDATA, d); check("R6 data upper zero", d, 16'h00FF);
    endtask

    task automatic t_status_and_map();
        logic [15:0] d;
        offer_key(8'h07);
        bus_write(KSTAT, 16'h0000);
        bus_write(DSTAT, 16'h0000);
        bus_read(KSTAT, d); check("R6 kstat write ignored", d, 16'h8000);
        bus_read(DSTAT, d); check("R6 dstat write ignored", d, 16'h8000);
        bus_read(16'hF402, d); check("R5 unmapped F402", d, 16'h0000);
        bus_read(16'hF3FD, d); check("R5 unmapped F3FD", d, 16'h0000);
        check("R5 unmapped read keeps lock", 16'(key_ready), 16'd0);
        bus_read(KDATA, d); check("R5 kdata address", d, 16'h0007);
    endtask

    task automatic t_display();
        logic [15:0] d;
        out_ready = 1'b0;
        bus_write(DDATA, 16'h1263);
        check("R7 out_valid", 16'(out_valid), 16'd1);
        check("R7 out_char", 16'(out_char), 16'h0063);
        bus_read(DSTAT, d); check("R7 dstat busy", d, 16'h0000);
        bus_write(DDATA, 16'h0064);
        check("R9 busy store ignored", 16'(out_char), 16'h0063);
        bus_read(DDATA, d); check("R10 ddata readback", d, 16'h0063);
        repeat (3) @(negedge clk);
        check("R8 held valid", 16'(out_valid), 16'd1);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check("R8 drained", 16'(out_valid), 16'd0);
        bus_read(DSTAT, d); check("R8 dstat ready", d, 16'h8000);
        out_ready = 1'b1;
        bus_write(DDATA, 16'h0021);
        check("R7 second char", 16'(out_char), 16'h0021);
        check("R8 valid with ready high", 16'(out_valid), 16'd1);
        @(negedge clk);
        check("R8 drained in one cycle", 16'(out_valid), 16'd0);
        out_ready = 1'b0;
        bus_read(DDATA, d); check("R10 last char", d, 16'h0021);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_key_lock();
        t_status_and_map();
        t_display();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 5000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule